// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Control

This block is the central control of a processor that issues one three-address instruction per clock to a small pool of functional units and lets those units run concurrently. Each instruction names a unit, an operation code, a destination register (i) and two source registers (j, k) in an eight-entry file of 60-bit operand registers. The block owns that register file. It decides when an instruction may issue, when each unit may begin its work, and when each finished unit may write its result back. Issue order is never changed. Dependencies are resolved by holding the issue, holding the start, or holding the write.

Every register carries a producer tag. The tag holds the number of the unit that will write the register, or a reserved code meaning that no write is pending. At issue, a unit records its three register designators, the producer tags of its two sources and one ready flag per source. A finished unit raises a release request. When it is granted the store, it writes the register file and broadcasts its number. Any waiting unit that was tagged with that number then marks the matching source ready. The functional units themselves, and their arithmetic, are outside the block. They see a start pulse together with the operand values, and they return a result together with a release request.

Top module: `scoreboard_ctl`

## Requirements
- R1: An issue request whose selected unit is still reserved by an earlier instruction is stalled (`iss_stall_o` high in that cycle). The unit stays reserved from the clock edge that accepts its instruction until the clock edge at which its store is granted.
- R2: An issue request whose destination register already has a pending producer is stalled. An accepted issue writes the unit number as the destination's producer tag. The no-pending code is 4'd8 and unit numbers run from 0 upward. A source whose tag holds the no-pending code is marked ready at issue.
- R3: When a unit's store is granted, every waiting unit whose recorded source tag equals that unit's number marks that source ready at the same edge. This includes an instruction that is issued in the very cycle of the release.
- R4: `start_o[u]` is high for exactly one cycle, in every cycle in which unit u is reserved, has not yet started, and has both sources ready. Starting clears both ready flags. `start_op_o` carries the unit's operation code in that cycle.
- R5: While `start_o[u]` is high, the operand outputs of unit u carry the current register-file values of its j and k registers.
- R6: A release request from unit u is not granted while any unit that has not yet started has a ready flag set on a source that names u's destination register.
- R7: Only a started unit that is requesting release can be granted. At most one grant is given per cycle, and among the eligible requesters the lowest-numbered unit wins.
- R8: On the edge after a grant, the register named by the unit's destination takes the unit's result, and that register's producer tag returns to no-pending if it still names that unit. The unit becomes free. For that one cycle, `wb_valid_o`, `wb_reg_o` and `wb_data_o` show the write.
- R9: After reset all tags hold the no-pending code, all registers read zero, no unit is reserved, and start, grant and writeback outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | Instruction presented for issue |
| iss_unit_i | input | UID_W | Target functional unit |
| iss_op_i | input | OP_W | Operation code passed to the unit |
| iss_fi_i | input | RIDX_W | Destination register |
| iss_fj_i | input | RIDX_W | First source register |
| iss_fk_i | input | RIDX_W | Second source register |
| iss_stall_o | output | 1 | Presented instruction is held this cycle |
| start_o | output | NUM_UNITS | Per-unit operands-ready start pulse |
| start_op_o | output | NUM_UNITS*OP_W | Per-unit operation code |
| opnd_j_o | output | NUM_UNITS*DATA_W | Per-unit value of the j register |
| opnd_k_o | output | NUM_UNITS*DATA_W | Per-unit value of the k register |
| rel_req_i | input | NUM_UNITS | Per-unit result ready, asking to store |
| rel_data_i | input | NUM_UNITS*DATA_W | Per-unit result value |
| go_store_o | output | NUM_UNITS | Per-unit store grant |
| wb_valid_o | output | 1 | A register was written at the last edge |
| wb_reg_o | output | RIDX_W | Register that was written |
| wb_data_o | output | DATA_W | Value that was written |

## Verification
The bench drives hand-written and pseudo-random instruction streams across four units with varied latencies. It predicts every stall, start, grant and writeback cycle from its own record of tags and ready flags, and compares the final register contents with plain in-order execution. The stimulus targets the following cases:
- A producer that releases in the same cycle as a dependent issue. A design without the same-cycle path would leave the dependent instruction waiting forever.
- A fast writer racing a slow reader of the same register. A design without the all-clear gate would overwrite the operand before it is read.
- Two units finishing together. A wrong arbiter would grant both, or grant the wrong one.
- A register that is rewritten after its tag was reused. A design that cleared the tag unconditionally would drop a pending reservation and let a later reader start too early.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int TAG_W = 4;

    typedef logic [TAG_W-1:0] tag_t;

    // Reserved producer tag: no result is pending for the register.
    localparam tag_t TAG_NONE = tag_t'(8);

endpackage

// File: rtl/sb_allclear.sv
// Per-register all-clear: a register is blocked for writing while any
// unit holds a set ready flag on a source naming it.
module sb_allclear #(
    parameter int NUM_UNITS = 4,
    parameter int NUM_REGS  = 8,
    parameter int RIDX_W    = 3
) (
    input  logic [NUM_UNITS-1:0] rd_j_i,
    input  logic [NUM_UNITS-1:0] rd_k_i,
    input  logic [RIDX_W-1:0]    fj_i [NUM_UNITS],
    input  logic [RIDX_W-1:0]    fk_i [NUM_UNITS],
    output logic [NUM_REGS-1:0]  clear_o
);

    logic [NUM_REGS-1:0] held;

    always_comb begin
        held = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (rd_j_i[u] && (fj_i[u] == RIDX_W'(r))) held[r] = 1'b1;
                if (rd_k_i[u] && (fk_i[u] == RIDX_W'(r))) held[r] = 1'b1;
            end
        end
        clear_o = ~held;
    end

endmodule

// File: rtl/sb_release_arb.sv
// Fixed-priority store arbiter: lowest-numbered requester wins.
module sb_release_arb #(
    parameter int NUM_UNITS = 4
) (
    input  logic [NUM_UNITS-1:0] req_i,
    output logic [NUM_UNITS-1:0] grant_o
);

    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_o = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (req_i[u] && !taken) begin
                grant_o[u] = 1'b1;
                taken      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sb_unit_slot.sv
// Status held by the scoreboard on behalf of one functional unit.
module sb_unit_slot
    import sb_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [RIDX_W-1:0] fi_i,
    input  logic [RIDX_W-1:0] fj_i,
    input  logic [RIDX_W-1:0] fk_i,
    input  tag_t              qj_i,
    input  tag_t              qk_i,
    input  logic              rel_valid_i,
    input  tag_t              rel_tag_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic              running_o,
    output logic              start_o,
    output logic              rd_j_o,
    output logic              rd_k_o,
    output logic [OP_W-1:0]   op_o,
    output logic [RIDX_W-1:0] fi_o,
    output logic [RIDX_W-1:0] fj_o,
    output logic [RIDX_W-1:0] fk_o
);

    typedef struct packed {
        logic              busy;
        logic              running;
        logic [OP_W-1:0]   op;
        logic [RIDX_W-1:0] fi;
        logic [RIDX_W-1:0] fj;
        logic [RIDX_W-1:0] fk;
        tag_t              qj;
        tag_t              qk;
        logic              rj;
        logic              rk;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  fire;

    always_comb begin
        slot_d = slot_q;
        fire   = slot_q.busy && !slot_q.running && slot_q.rj && slot_q.rk;

        if (fire) begin
            slot_d.running = 1'b1;
            slot_d.rj      = 1'b0;
            slot_d.rk      = 1'b0;
        end else if (slot_q.busy && !slot_q.running && rel_valid_i) begin
            if (!slot_q.rj && (slot_q.qj == rel_tag_i)) slot_d.rj = 1'b1;
            if (!slot_q.rk && (slot_q.qk == rel_tag_i)) slot_d.rk = 1'b1;
        end

        if (grant_i) begin
            slot_d.busy    = 1'b0;
            slot_d.running = 1'b0;
        end

        if (issue_i) begin
            slot_d.busy    = 1'b1;
            slot_d.running = 1'b0;
            slot_d.op      = op_i;
            slot_d.fi      = fi_i;
            slot_d.fj      = fj_i;
            slot_d.fk      = fk_i;
            slot_d.qj      = qj_i;
            slot_d.qk      = qk_i;
            slot_d.rj      = (qj_i == TAG_NONE) || (rel_valid_i && (qj_i == rel_tag_i));
            slot_d.rk      = (qk_i == TAG_NONE) || (rel_valid_i && (qk_i == rel_tag_i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q    <= '0;
            slot_q.qj <= TAG_NONE;
            slot_q.qk <= TAG_NONE;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign busy_o    = slot_q.busy;
    assign running_o = slot_q.running;
    assign start_o   = fire;
    assign rd_j_o    = slot_q.rj;
    assign rd_k_o    = slot_q.rk;
    assign op_o      = slot_q.op;
    assign fi_o      = slot_q.fi;
    assign fj_o      = slot_q.fj;
    assign fk_o      = slot_q.fk;

endmodule

// File: rtl/scoreboard_ctl.sv
// Scoreboard: in-order issue, operand-ready start, all-clear gated store.
module scoreboard_ctl
    import sb_pkg::*;
#(
    parameter  int NUM_UNITS = 4,
    parameter  int NUM_REGS  = 8,
    parameter  int DATA_W    = 60,
    parameter  int OP_W      = 4,
    localparam int RIDX_W    = $clog2(NUM_REGS),
    localparam int UID_W     = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_valid_i,
    input  logic [UID_W-1:0]            iss_unit_i,
    input  logic [OP_W-1:0]             iss_op_i,
    input  logic [RIDX_W-1:0]           iss_fi_i,
    input  logic [RIDX_W-1:0]           iss_fj_i,
    input  logic [RIDX_W-1:0]           iss_fk_i,
    output logic                        iss_stall_o,
    output logic [NUM_UNITS-1:0]        start_o,
    output logic [NUM_UNITS*OP_W-1:0]   start_op_o,
    output logic [NUM_UNITS*DATA_W-1:0] opnd_j_o,
    output logic [NUM_UNITS*DATA_W-1:0] opnd_k_o,
    input  logic [NUM_UNITS-1:0]        rel_req_i,
    input  logic [NUM_UNITS*DATA_W-1:0] rel_data_i,
    output logic [NUM_UNITS-1:0]        go_store_o,
    output logic                        wb_valid_o,
    output logic [RIDX_W-1:0]           wb_reg_o,
    output logic [DATA_W-1:0]           wb_data_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0][TAG_W-1:0]  tag;
        logic [NUM_REGS-1:0][DATA_W-1:0] xreg;
        logic                            wb_valid;
        logic [RIDX_W-1:0]               wb_reg;
        logic [DATA_W-1:0]               wb_data;
    } core_t;

    core_t core_d, core_q;

    logic [NUM_UNITS-1:0] busy, running, rd_j, rd_k, grant, eligible, issue_sel;
    logic [OP_W-1:0]      slot_op [NUM_UNITS];
    logic [RIDX_W-1:0]    slot_fi [NUM_UNITS];
    logic [RIDX_W-1:0]    slot_fj [NUM_UNITS];
    logic [RIDX_W-1:0]    slot_fk [NUM_UNITS];
    logic [NUM_REGS-1:0]  clear;

    logic              accept;
    logic              rel_valid;
    tag_t              rel_tag;
    logic [RIDX_W-1:0] rel_fi;
    logic [DATA_W-1:0] rel_val;
    tag_t              src_tag_j, src_tag_k;

    // Issue: first-order conflict check
    always_comb begin
        iss_stall_o = iss_valid_i &&
                      (busy[iss_unit_i] || (tag_t'(core_q.tag[iss_fi_i]) != TAG_NONE));
        accept      = iss_valid_i && !iss_stall_o;
        src_tag_j   = tag_t'(core_q.tag[iss_fj_i]);
        src_tag_k   = tag_t'(core_q.tag[iss_fk_i]);
        for (int u = 0; u < NUM_UNITS; u++) begin
            issue_sel[u] = accept && (iss_unit_i == UID_W'(u));
        end
    end

    // Unit status slots
    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
            sb_unit_slot #(
                .OP_W   (OP_W),
                .RIDX_W (RIDX_W)
            ) u_slot (
                .clk         (clk),
                .rst_n       (rst_n),
                .issue_i     (issue_sel[u]),
                .op_i        (iss_op_i),
                .fi_i        (iss_fi_i),
                .fj_i        (iss_fj_i),
                .fk_i        (iss_fk_i),
                .qj_i        (src_tag_j),
                .qk_i        (src_tag_k),
                .rel_valid_i (rel_valid),
                .rel_tag_i   (rel_tag),
                .grant_i     (grant[u]),
                .busy_o      (busy[u]),
                .running_o   (running[u]),
                .start_o     (start_o[u]),
                .rd_j_o      (rd_j[u]),
                .rd_k_o      (rd_k[u]),
                .op_o        (slot_op[u]),
                .fi_o        (slot_fi[u]),
                .fj_o        (slot_fj[u]),
                .fk_o        (slot_fk[u])
            );

            assign start_op_o[u*OP_W +: OP_W]   = slot_op[u];
            assign opnd_j_o[u*DATA_W +: DATA_W] = core_q.xreg[slot_fj[u]];
            assign opnd_k_o[u*DATA_W +: DATA_W] = core_q.xreg[slot_fk[u]];
            assign eligible[u] = rel_req_i[u] && running[u] && clear[slot_fi[u]];
        end
    endgenerate

    // Third-order conflict: all-clear per register
    sb_allclear #(
        .NUM_UNITS (NUM_UNITS),
        .NUM_REGS  (NUM_REGS),
        .RIDX_W    (RIDX_W)
    ) u_allclear (
        .rd_j_i  (rd_j),
        .rd_k_i  (rd_k),
        .fj_i    (slot_fj),
        .fk_i    (slot_fk),
        .clear_o (clear)
    );

    sb_release_arb #(
        .NUM_UNITS (NUM_UNITS)
    ) u_arb (
        .req_i   (eligible),
        .grant_o (grant)
    );

    assign go_store_o = grant;

    // Release broadcast: tag, destination and data of the granted unit
    always_comb begin
        rel_valid = |grant;
        rel_tag   = TAG_NONE;
        rel_fi    = '0;
        rel_val   = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (grant[u]) begin
                rel_tag = tag_t'(u);
                rel_fi  = slot_fi[u];
                rel_val = rel_data_i[u*DATA_W +: DATA_W];
            end
        end
    end

    // Tag file, register file and writeback report
    always_comb begin
        core_d          = core_q;
        core_d.wb_valid = 1'b0;
        if (rel_valid) begin
            core_d.xreg[rel_fi] = rel_val;
            if (tag_t'(core_q.tag[rel_fi]) == rel_tag) begin
                core_d.tag[rel_fi] = TAG_NONE;
            end
            core_d.wb_valid = 1'b1;
            core_d.wb_reg   = rel_fi;
            core_d.wb_data  = rel_val;
        end
        if (accept) begin
            core_d.tag[iss_fi_i] = tag_t'(iss_unit_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_q <= '0;
            for (int r = 0; r < NUM_REGS; r++) begin
                core_q.tag[r] <= TAG_NONE;
            end
        end else begin
            core_q <= core_d;
        end
    end

    assign wb_valid_o = core_q.wb_valid;
    assign wb_reg_o   = core_q.wb_reg;
    assign wb_data_o  = core_q.wb_data;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NU    = 4,
    parameter int UID_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [UID_W-1:0] iss_unit,
    input logic             iss_stall,
    input logic [NU-1:0]    start,
    input logic [NU-1:0]    go_store,
    input logic [NU-1:0]    rel_req,
    input logic             wb_valid
);

    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(go_store));

    assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((go_store & ~rel_req) == '0));

    assert_wb_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|go_store) |=> wb_valid);

    assert_no_wb_without_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|go_store) |=> !wb_valid);

    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|start) |=> ((start & $past(start)) == '0));

    assert_busy_unit_stalls_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_stall) |=>
            (!(iss_valid && (iss_unit == $past(iss_unit))) || iss_stall));

endmodule

bind scoreboard_ctl sb_checker #(
    .NU    (NUM_UNITS),
    .UID_W (UID_W)
) u_sb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid_i),
    .iss_unit  (iss_unit_i),
    .iss_stall (iss_stall_o),
    .start     (start_o),
    .go_store  (go_store_o),
    .rel_req   (rel_req_i),
    .wb_valid  (wb_valid_o)
);

// File: tb/tb_scoreboard_ctl.sv
`timescale 1ns/1ps
module tb_scoreboard_ctl;

    localparam int NU = 4;
    localparam int NR = 8;
    localparam int DW = 60;
    localparam int OW = 4;

    typedef struct {
        int          unit;
        int          op;
        int          fi;
        int          fj;
        int          fk;
        logic [59:0] imm;
        int          lat;
    } instr_t;

    logic clk = 1'b0;
    logic rst_n;
    logic iss_valid;
    logic [1:0] iss_unit;
    logic [OW-1:0] iss_op;
    logic [2:0] iss_fi, iss_fj, iss_fk;
    logic iss_stall;
    logic [NU-1:0] start;
    logic [NU*OW-1:0] start_op;
    logic [NU*DW-1:0] opnd_j, opnd_k;
    logic [NU-1:0] rel_req;
    logic [NU*DW-1:0] rel_data;
    logic [NU-1:0] go_store;
    logic wb_valid;
    logic [2:0] wb_reg;
    logic [DW-1:0] wb_data;

    always #5 clk = ~clk;

    scoreboard_ctl dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid_i(iss_valid), .iss_unit_i(iss_unit), .iss_op_i(iss_op),
        .iss_fi_i(iss_fi), .iss_fj_i(iss_fj), .iss_fk_i(iss_fk),
        .iss_stall_o(iss_stall), .start_o(start), .start_op_o(start_op),
        .opnd_j_o(opnd_j), .opnd_k_o(opnd_k),
        .rel_req_i(rel_req), .rel_data_i(rel_data), .go_store_o(go_store),
        .wb_valid_o(wb_valid), .wb_reg_o(wb_reg), .wb_data_o(wb_data)
    );

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    instr_t prog [64];
    int prog_len, pc;
    bit use_gaps;
    logic [31:0] seed = 32'h1234_5678;

    // bench model of the units and of the scoreboard's obligations
    bit inflight [NU], started [NU], jdone [NU], kdone [NU], req [NU], start_now [NU];
    int prodj [NU], prodk [NU], cnt [NU];
    instr_t cur [NU];
    logic [59:0] res [NU], opa [NU], opb [NU];
    int btag [NR];
    logic [59:0] shadow [NR], golden [NR];
    int pend_acc = -1, pend_rel = -1;
    bit exp_wb_v = 0;
    int exp_wb_reg = 0;
    logic [59:0] exp_wb_data = '0;

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic logic [59:0] alu(int op, logic [59:0] a, logic [59:0] b, logic [59:0] imm);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a ^ b;
            default: return imm;
        endcase
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic step();
        bit exp_stall;
        bit blk [NR];
        logic [NU-1:0] exp_go;
        int g;
        @(negedge clk);
        // events of the last edge: issue first, then release
        if (pend_acc >= 0) begin
            int u = pend_acc;
            instr_t in = prog[pc];
            inflight[u] = 1; started[u] = 0; req[u] = 0; cur[u] = in;
            prodj[u] = btag[in.fj]; prodk[u] = btag[in.fk];
            jdone[u] = (prodj[u] < 0); kdone[u] = (prodk[u] < 0);
            btag[in.fi] = u;
            golden[in.fi] = alu(in.op, golden[in.fj], golden[in.fk], in.imm);
            pc++;
        end
        if (pend_rel >= 0) begin
            int u = pend_rel;
            inflight[u] = 0; req[u] = 0;
            if (btag[cur[u].fi] == u) btag[cur[u].fi] = -1;
            for (int v = 0; v < NU; v++) begin
                if (inflight[v] && !started[v]) begin
                    if (prodj[v] == u) jdone[v] = 1;
                    if (prodk[v] == u) kdone[v] = 1;
                end
            end
        end
        for (int v = 0; v < NU; v++) begin
            if (inflight[v] && started[v] && !req[v]) begin
                cnt[v]--;
                if (cnt[v] <= 0) req[v] = 1;
            end
        end
        for (int v = 0; v < NU; v++) begin
            if (start_now[v]) begin
                started[v] = 1; start_now[v] = 0; cnt[v] = cur[v].lat;
                res[v] = alu(cur[v].op, opa[v], opb[v], cur[v].imm);
            end
        end
        // R8: writeback report one cycle after the grant
        chk(wb_valid == exp_wb_v, "R8", "wb_valid", 64'(wb_valid), 64'(exp_wb_v));
        if (exp_wb_v) begin
            chk(wb_reg == 3'(exp_wb_reg), "R8", "wb_reg", 64'(wb_reg), 64'(exp_wb_reg));
            chk(wb_data == exp_wb_data, "R8", "wb_data", 64'(wb_data), 64'(exp_wb_data));
        end
        if (wb_valid) shadow[wb_reg] = wb_data;
        // drive
        if (pc < prog_len && !(use_gaps && (rnd() % 4 == 0))) begin
            iss_valid = 1;
            iss_unit = 2'(prog[pc].unit); iss_op = OW'(prog[pc].op);
            iss_fi = 3'(prog[pc].fi); iss_fj = 3'(prog[pc].fj); iss_fk = 3'(prog[pc].fk);
        end else begin
            iss_valid = 0;
        end
        for (int v = 0; v < NU; v++) begin
            rel_req[v] = req[v];
            rel_data[v*DW +: DW] = res[v];
        end
        #1;
        // R1 / R2: stall prediction
        if (iss_valid) begin
            exp_stall = inflight[iss_unit] || (btag[iss_fi] >= 0);
            chk(iss_stall == exp_stall, inflight[iss_unit] ? "R1" : "R2", "iss_stall",
                64'(iss_stall), 64'(exp_stall));
        end
        pend_acc = (iss_valid && !iss_stall) ? int'(iss_unit) : -1;
        // R3 / R4 / R5: start and operands
        for (int v = 0; v < NU; v++) begin
            bit es = inflight[v] && !started[v] && jdone[v] && kdone[v];
            chk(start[v] == es, (prodj[v] >= 0 || prodk[v] >= 0) ? "R3" : "R4",
                $sformatf("start unit %0d", v), 64'(start[v]), 64'(es));
            if (start[v] && inflight[v]) begin
                start_now[v] = 1;
                opa[v] = opnd_j[v*DW +: DW];
                opb[v] = opnd_k[v*DW +: DW];
                chk(opa[v] == shadow[cur[v].fj], "R5", "operand j", 64'(opa[v]), 64'(shadow[cur[v].fj]));
                chk(opb[v] == shadow[cur[v].fk], "R5", "operand k", 64'(opb[v]), 64'(shadow[cur[v].fk]));
                chk(start_op[v*OW +: OW] == OW'(cur[v].op), "R4", "start op",
                    64'(start_op[v*OW +: OW]), 64'(cur[v].op));
            end
        end
        // R6 / R7: store grant
        for (int r = 0; r < NR; r++) blk[r] = 0;
        for (int v = 0; v < NU; v++) begin
            if (inflight[v] && !started[v]) begin
                if (jdone[v]) blk[cur[v].fj] = 1;
                if (kdone[v]) blk[cur[v].fk] = 1;
            end
        end
        exp_go = '0; g = -1;
        for (int v = 0; v < NU; v++) begin
            if (req[v] && blk[cur[v].fi]) begin
                chk(go_store[v] == 1'b0, "R6", $sformatf("grant to blocked unit %0d", v),
                    64'(go_store[v]), 64'd0);
            end
            if (req[v] && !blk[cur[v].fi] && g < 0) g = v;
        end
        if (g >= 0) exp_go[g] = 1'b1;
        chk(go_store == exp_go, "R7", "go_store", 64'(go_store), 64'(exp_go));
        pend_rel = -1;
        for (int v = NU - 1; v >= 0; v--) if (go_store[v]) pend_rel = v;
        exp_wb_v = (pend_rel >= 0);
        if (exp_wb_v) begin
            exp_wb_reg = cur[pend_rel].fi;
            exp_wb_data = res[pend_rel];
        end
    endtask

    task automatic run_program();
        bit busy_any;
        pc = 0;
        do begin
            step();
            busy_any = 0;
            for (int v = 0; v < NU; v++) busy_any |= inflight[v];
        end while (pc < prog_len || busy_any || pend_acc >= 0 || pend_rel >= 0);
        repeat (2) step();
        // R8: final register file equals in-order execution
        for (int r = 0; r < NR; r++) begin
            chk(shadow[r] == golden[r], "R8", $sformatf("final X%0d", r),
                64'(shadow[r]), 64'(golden[r]));
        end
    endtask

    function automatic instr_t mk(int u, int op, int fi, int fj, int fk, logic [59:0] imm, int lat);
        instr_t t;
        t.unit = u; t.op = op; t.fi = fi; t.fj = fj; t.fk = fk; t.imm = imm; t.lat = lat;
        return t;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 0; iss_valid = 0; iss_unit = 0; iss_op = 0;
        iss_fi = 0; iss_fj = 0; iss_fk = 0; rel_req = '0; rel_data = '0;
        for (int v = 0; v < NU; v++) begin
            inflight[v] = 0; started[v] = 0; req[v] = 0; start_now[v] = 0;
            prodj[v] = -1; prodk[v] = -1; cnt[v] = 0; res[v] = '0;
        end
        for (int r = 0; r < NR; r++) begin
            btag[r] = -1; shadow[r] = '0; golden[r] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R9: quiet outputs after reset
        chk(start == '0, "R9", "start after reset", 64'(start), 64'd0);
        chk(go_store == '0, "R9", "go_store after reset", 64'(go_store), 64'd0);
        chk(wb_valid == 1'b0, "R9", "wb_valid after reset", 64'(wb_valid), 64'd0);
        chk(iss_stall == 1'b0, "R9", "stall after reset", 64'(iss_stall), 64'd0);
        chk(opnd_j == '0, "R9", "registers zero after reset", 64'(opnd_j[59:0]), 64'd0);

        // directed: RAW wait, WAR race, busy reuse, simultaneous finish
        use_gaps = 0;
        prog[0] = mk(0, 3, 1, 0, 0, 60'd5, 8);
        prog[1] = mk(1, 0, 2, 1, 0, 60'd0, 2);
        prog[2] = mk(3, 3, 0, 0, 0, 60'd9, 1);
        prog[3] = mk(2, 0, 3, 0, 2, 60'd0, 1);
        prog[4] = mk(0, 3, 4, 0, 0, 60'd7, 1);
        prog[5] = mk(1, 1, 4, 3, 4, 60'd0, 1);
        prog[6] = mk(2, 3, 5, 0, 0, 60'd11, 3);
        prog[7] = mk(3, 3, 6, 0, 0, 60'd13, 2);
        prog[8] = mk(0, 2, 7, 5, 6, 60'd0, 1);
        prog_len = 9;
        run_program();

        // pseudo-random sweeps
        use_gaps = 1;
        for (int p = 0; p < 60; p++) begin
            prog_len = 20;
            for (int i = 0; i < prog_len; i++) begin
                prog[i] = mk(int'(rnd() % 4), int'(rnd() % 4), int'(rnd() % 8),
                             int'(rnd() % 8), int'(rnd() % 8),
                             {rnd(), rnd()} >> 4, 1 + int'(rnd() % 6));
            end
            run_program();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule